// File: doc/BRIEF.md
# Fractional-Increment System Time Counter

This block keeps a free-running 64-bit time value for a network controller. Rather than counting one per clock, it waits a programmable number of reference clock ticks and then adds a programmable 24-bit step to the time. The step is scaled left as far as it fits, so the low-order bits of the time hold fractions of a nanosecond. Software tunes the rate of the clock by adjusting the step, and the counter wraps silently modulo 2^64.

A small register port serves the host. It can write a control word that holds the tick period and the step, and it can load a new time as two 32-bit halves. It reads the time through a snapshot, so a 64-bit value read as two halves is always consistent. A control word written while the counter runs takes effect at the next period boundary, so time already accumulated is never disturbed. The full time value is also driven on an output for local timestamp consumers.

Top module: `systime_counter`

## Requirements
- R1: A synchronous active-high reset clears the time, the tick counter, the active and pending control words and the high-half snapshot. After reset, all three register reads and `sys_time` return zero.
- R2: Address 0 holds the control word: bits 31:24 set the tick period and bits 23:0 set the step. A read of address 0 returns the last word written there.
- R3: While the active period P is non-zero, the time grows by exactly the active step once every P clock cycles. Any window of k·P cycles with no host writes therefore adds k steps, and the carry propagates across the 32-bit boundary.
- R4: While the active period is zero, the time holds its value.
- R5: A read of address 1 returns the live low half and captures the high half into a snapshot. A read of address 2 returns that snapshot, even if the live high half has changed since.
- R6: A write to address 1 stages a low half. A following write to address 2 loads {written high, staged low} into the time on that write's clock edge, and the tick counter restarts, so the next step lands P cycles later.
- R7: A control word written while counting becomes active at the next period boundary and keeps the accumulated time. If the active period is zero, the new word becomes active on the next cycle.
- R8: Adding a step past 2^64−1 wraps the time modulo 2^64 with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; a read of address 1 captures the snapshot |
| addr | input | 2 | Register select: 0 control, 1 low half, 2 high half |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data for the selected register while rd_en is high, else zero |
| sys_time | output | 64 | Live time value |

## Verification
The bench runs a cycle-by-cycle model of the time and compares every register read against it. It also makes hand-computed checks:
- Over a window of whole periods, the time must advance by an exact multiple of the step. A design with an off-by-one divider drifts and fails this.
- The high-half read is made after the live high half has rolled over. A design without the snapshot returns the new value, not the captured one.
- The period is changed in mid-run, and the time is then checked on every cycle. A design that applies the new word at once, or that clears the time when the word changes, shows up here.
- A load just below 2^64 must wrap cleanly.
- A load in mid-period must restart the divider, or the next step arrives early.

// File: rtl/systime_pkg.sv
package systime_pkg;
    localparam int DEF_PER_W = 8;
    localparam int DEF_INC_W = 24;
    localparam logic [1:0] ADR_CTL = 2'd0;
    localparam logic [1:0] ADR_LO  = 2'd1;
    localparam logic [1:0] ADR_HI  = 2'd2;
endpackage

// File: rtl/systime_tick.sv
module systime_tick #(
    parameter int PER_W = systime_pkg::DEF_PER_W,
    parameter int INC_W = systime_pkg::DEF_INC_W,
    localparam int DATA_W = PER_W + INC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pend_ctl,
    input  logic              restart,
    output logic              tick,
    output logic [PER_W-1:0]  act_period,
    output logic [INC_W-1:0]  act_incr
);
    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic [PER_W-1:0]  cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     idle;

    always_comb begin
        st_d       = st_q;
        act_period = st_q.ctl[DATA_W-1:INC_W];
        act_incr   = st_q.ctl[INC_W-1:0];
        idle       = (act_period == '0);
        tick       = !idle && (st_q.cnt == act_period - PER_W'(1));
        // a new word is adopted only at a boundary, or at once when stopped
        if (idle || tick) begin
            st_d.ctl = pend_ctl;
        end
        if (restart || idle || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
    parameter int INC_W  = systime_pkg::DEF_INC_W,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [INC_W-1:0]  incr,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_o
);
    typedef struct packed {
        logic [TIME_W-1:0] t;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.t = load_val;
        end else if (tick) begin
            st_d.t = st_q.t + TIME_W'(incr);
        end
        time_o = st_q.t;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/systime_host.sv
module systime_host #(
    parameter int PER_W = systime_pkg::DEF_PER_W,
    parameter int INC_W = systime_pkg::DEF_INC_W,
    localparam int DATA_W = PER_W + INC_W,
    localparam int TIME_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] live_time,
    output logic [DATA_W-1:0] pend_ctl,
    output logic              load,
    output logic [TIME_W-1:0] load_val,
    output logic [DATA_W-1:0] rdata
);
    import systime_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] lo_stage;
        logic [DATA_W-1:0] shadow;
    } host_st_t;

    host_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADR_CTL) st_d.pend     = wdata;
        if (wr_en && addr == ADR_LO)  st_d.lo_stage = wdata;
        if (rd_en && addr == ADR_LO)  st_d.shadow   = live_time[TIME_W-1:DATA_W];

        pend_ctl = st_q.pend;
        load     = wr_en && (addr == ADR_HI);
        load_val = {wdata, st_q.lo_stage};

        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADR_CTL: rdata = st_q.pend;
                ADR_LO:  rdata = live_time[DATA_W-1:0];
                ADR_HI:  rdata = st_q.shadow;
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/systime_counter.sv
module systime_counter #(
    parameter int PER_W = systime_pkg::DEF_PER_W,
    parameter int INC_W = systime_pkg::DEF_INC_W,
    localparam int DATA_W = PER_W + INC_W,
    localparam int TIME_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [TIME_W-1:0] sys_time
);
    logic [DATA_W-1:0] pend_ctl_w;
    logic              load_w;
    logic [TIME_W-1:0] load_val_w;
    logic              tick_w;
    logic [PER_W-1:0]  act_period_w;
    logic [INC_W-1:0]  act_incr_w;

    systime_host #(.PER_W(PER_W), .INC_W(INC_W)) u_host (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .live_time(sys_time), .pend_ctl(pend_ctl_w),
        .load(load_w), .load_val(load_val_w), .rdata(rdata)
    );

    systime_tick #(.PER_W(PER_W), .INC_W(INC_W)) u_tick (
        .clk(clk), .rst(rst), .pend_ctl(pend_ctl_w), .restart(load_w),
        .tick(tick_w), .act_period(act_period_w), .act_incr(act_incr_w)
    );

    systime_accum #(.INC_W(INC_W), .TIME_W(TIME_W)) u_accum (
        .clk(clk), .rst(rst), .tick(tick_w), .incr(act_incr_w),
        .load(load_w), .load_val(load_val_w), .time_o(sys_time)
    );
endmodule

// File: rtl/systime_checker.sv
module systime_checker #(
    parameter int PER_W = systime_pkg::DEF_PER_W,
    parameter int INC_W = systime_pkg::DEF_INC_W,
    localparam int DATA_W = PER_W + INC_W,
    localparam int TIME_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [TIME_W-1:0] sys_time,
    input logic              tick,
    input logic [PER_W-1:0]  act_period,
    input logic [INC_W-1:0]  act_incr
);
    logic seen_q;
    logic hi_wr;

    always_ff @(posedge clk) seen_q <= 1'b1;
    assign hi_wr = wr_en && (addr == 2'd2);

    assert_reset_clear_R1: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (sys_time == '0));

    assert_step_add_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !hi_wr) |=> (sys_time == $past(sys_time + TIME_W'(act_incr))));

    assert_no_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hi_wr) |=> $stable(sys_time));

    assert_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (act_period == '0) |-> !tick);

    assert_load_high_R6: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (sys_time[TIME_W-1:DATA_W] == $past(wdata)));
endmodule

bind systime_counter systime_checker #(.PER_W(PER_W), .INC_W(INC_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sys_time(sys_time), .tick(tick_w), .act_period(act_period_w),
    .act_incr(act_incr_w)
);

// File: tb/systime_counter_test.sv
module systime_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] sys_time;

    int n_chk = 0;
    int n_fail = 0;

    systime_counter uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_time(sys_time)
    );

    always #4 clk = ~clk;

    // behavioural expectation of the time, built from the requirements
    logic [63:0] m_time;
    logic [31:0] m_act, m_pend, m_lo, m_shadow;
    int          m_cnt;
    always @(posedge clk) begin
        logic [7:0] per;
        logic       bnd, ld;
        if (rst) begin
            m_time <= '0; m_act <= '0; m_pend <= '0; m_lo <= '0;
            m_shadow <= '0; m_cnt <= 0;
        end else begin
            per = m_act[31:24];
            bnd = (per != 0) && (m_cnt == int'(per) - 1);
            ld  = wr_en && addr == 2'd2;
            if (ld)       m_time <= {wdata, m_lo};
            else if (bnd) m_time <= m_time + {40'd0, m_act[23:0]};
            m_cnt <= (ld || per == 0 || bnd) ? 0 : m_cnt + 1;
            if (per == 0 || bnd) m_act <= m_pend;
            if (wr_en && addr == 2'd0) m_pend <= wdata;
            if (wr_en && addr == 2'd1) m_lo <= wdata;
            if (rd_en && addr == 2'd1) m_shadow <= m_time[63:32];
        end
    end

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_rd;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        case (a)
            2'd0:    exp_q.push_back(m_pend);
            2'd1:    exp_q.push_back(m_time[31:0]);
            2'd2:    exp_q.push_back(m_shadow);
            default: exp_q.push_back(32'd0);
        endcase
        tag_q.push_back(tag);
    endtask

    task automatic peek(input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1 check(tag, sys_time, m_time);
    endtask

    task automatic peek_const(input string tag, input logic [63:0] expv);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1 check(tag, sys_time, expv);
    endtask

    task automatic delta(input int cyc, input logic [63:0] expv, input string tag);
        logic [63:0] a;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1 a = sys_time;
        repeat (cyc) @(negedge clk);
        #1 check(tag, sys_time - a, expv);
    endtask

    // monitor: pops the expected item for every read the design answers
    always @(negedge clk) begin
        logic [31:0] e;
        string       t;
        #2;
        if (rd_en && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_rd = rdata;
            check(t, {32'd0, rdata}, {32'd0, e});
        end
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek_const("R1 time", 64'd0);
        rd(2'd0, "R1 ctl"); rd(2'd1, "R1 lo"); rd(2'd2, "R1 hi");

        // R2 control word read-back; period 3, step 125<<14
        wr(2'd0, 32'h031F_4000);
        rd(2'd0, "R2 ctl");
        repeat (4) idle();
        // R3 twelve cycles are four whole periods
        delta(12, 64'd4 * 64'h1F_4000, "R3 delta");
        rd(2'd1, "R3 lo");
        peek("R3 time");

        // R4 stop counting, then hold
        wr(2'd0, 32'h0000_0080);
        repeat (5) idle();
        delta(7, 64'd0, "R4 hold");

        // R6 load while stopped
        wr(2'd1, 32'hFFFF_FF00);
        wr(2'd2, 32'h0000_0005);
        peek_const("R6 load", 64'h0000_0005_FFFF_FF00);
        peek_const("R4 stays", 64'h0000_0005_FFFF_FF00);

        // R5 snapshot: latch high=5, let high roll to 6, then read it
        wr(2'd0, 32'h0100_0080);
        rd(2'd1, "R5 lo");
        repeat (4) idle();
        rd(2'd2, "R5 hi");
        idle();
        check("R5 snapshot", {32'd0, last_rd}, 64'd5);
        check("R5 live high", {32'd0, sys_time[63:32]}, 64'd6);
        peek("R5 time");

        // R7 change period in mid-run; track every cycle
        wr(2'd0, 32'h0300_0100);
        for (int i = 0; i < 8; i++) peek("R7 per-cycle");
        delta(12, 64'd4 * 64'h100, "R7 new rate");
        wr(2'd0, 32'h0400_0010);
        for (int i = 0; i < 10; i++) peek("R7 switch");
        rd(2'd0, "R7 ctl");

        // R6 load mid-period restarts the divider
        wr(2'd1, 32'h0000_1000);
        wr(2'd2, 32'h0000_0007);
        for (int i = 0; i < 9; i++) peek("R6 restart");
        rd(2'd1, "R6 lo");
        rd(2'd2, "R6 hi");

        // R8 wrap past all-ones
        wr(2'd0, 32'h0000_0000);
        repeat (6) idle();
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0100_0020);
        for (int i = 0; i < 4; i++) peek("R8 wrap");
        check("R8 high zero", {32'd0, sys_time[63:32]}, 64'd0);
        rd(2'd1, "R8 lo");

        // R1 reset during operation clears the snapshot too
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000_0009);
        rd(2'd1, "R5 latch9");
        @(negedge clk);
        rd_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek_const("R1 mid reset", 64'd0);
        rd(2'd2, "R1 shadow");
        rd(2'd0, "R1 ctl2");
        idle();
        repeat (3) peek_const("R1 stays", 64'd0);
        idle();
        idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule